// File: doc/BRIEF.md
# Frame-Linear Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable timing for a video-mode serial display link. It also places pixels on the output. Vertical position is not tracked with a line counter. One linear pixel counter runs across the whole frame, starting at the first pixel of vertical sync. A separate horizontal counter runs within each line, starting at the first pixel of horizontal sync. The vertical sync length and the vertical active window are therefore programmed in pixel clocks, not in lines.

Software programs a shadow register set through a simple write port. The generator copies the whole shadow set into its working set at each frame boundary, so a frame never mixes old and new settings. The enable bit is shadowed in the same way: switching the generator off lets the current frame finish, and switching it on starts a frame at the next boundary.

Pixels arrive on a valid-qualified input and are accepted one cycle before they appear at the output. If the source has nothing to give during active video, the rest of that frame is filled with a programmable colour. Normal output resumes on its own at the next frame. A one-cycle frame strobe marks the first pixel of every frame.

Top module: `frame_tgen`

## Requirements
- R1: Writes go to a shadow set. The generator copies the shadow set into the working set at the frame boundary, after the last pixel of a frame. A write that lands in the same cycle as that copy takes effect one frame later. Register addresses:
  - 0: control. Bit 0 enables the generator, bit 1 makes hsync active-low, bit 2 makes vsync active-low.
  - 1: line timing. Bits [15:0] hold the line length, bits [31:16] hold the hsync pulse width.
  - 2: horizontal window. Bits [15:0] hold the first active column, bits [31:16] hold the last active column.
  - 3: frame length in pixels.
  - 4: vsync length in pixels.
  - 5: vertical start.
  - 6: vertical end.
  - 7: skew.
  - 8: fill colour, bits [23:0].
- R2: The linear count k runs 0 to frame length − 1 and then wraps to 0. `frameStrobe` is high for exactly the one output cycle where k = 0.
- R3: The asserted hsync state holds exactly while (k mod line length) < pulse width.
- R4: The asserted vsync state holds exactly while k < vsync length.
- R5: Control bit 1 inverts hsync and control bit 2 inverts vsync. With both bits clear, both syncs are active-high.
- R6: Data enable needs the column (k mod line length) to lie between the first and last active columns, both limits included.
- R7: Data enable also needs k to lie between vertical start + skew and vertical end + skew, both limits included.
- R8: In an active cycle, `pixOut` carries `pixIn` while `pixValid` is high. An active cycle with `pixValid` low is an underflow. From that cycle until the frame ends, every active pixel is the fill colour. The next frame is normal again. The fill colour resets to all ones. `pixOut` is zero outside active video.
- R9: Clearing the enable bit mid-frame lets that frame complete. After it, the generator is idle: no strobe, no data enable, and both syncs held at their inactive level. Setting the enable bit starts a new frame.
- R10: `pixReady` is high in the cycle a pixel is accepted, which is one cycle before that pixel's data-enable cycle at the output.
- R11: After reset, all outputs are low and the generator is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| pixIn | input | 24 | Incoming pixel |
| pixValid | input | 1 | Incoming pixel is present |
| pixReady | output | 1 | Pixel accepted this cycle |
| pixOut | output | 24 | Outgoing pixel |
| hsyncOut | output | 1 | Horizontal sync, polarity applied |
| vsyncOut | output | 1 | Vertical sync, polarity applied |
| deOut | output | 1 | Data enable |
| frameStrobe | output | 1 | One-cycle marker at k = 0 |

## Verification
The two functions that can fall in the same cycle are a software register write and the frame-boundary copy of the shadow set into the working set.

The bench provokes this by issuing a pulse-width write so that it is sampled on the very edge where the last pixel of a frame is evaluated. It then checks every pixel of the two following frames. The frame right after the write must still show the old pulse width, and the frame after that must show the new one.

Each frame of a small 10×7 mode is swept pixel by pixel, and all outputs are compared with values computed from the mode arithmetic.

// File: rtl/frame_tgen_pkg.sv
package frame_tgen_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] REG_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] REG_LINE   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_HWIN   = 4'd2;
  localparam logic [ADDR_W-1:0] REG_FRAME  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_VSLEN  = 4'd4;
  localparam logic [ADDR_W-1:0] REG_VSTART = 4'd5;
  localparam logic [ADDR_W-1:0] REG_VEND   = 4'd6;
  localparam logic [ADDR_W-1:0] REG_SKEW   = 4'd7;
  localparam logic [ADDR_W-1:0] REG_FILL   = 4'd8;

  // Control to datapath strobes.
  typedef struct packed {
    logic load;  // copy shadow set to working set, restart counters
    logic run;   // generator is producing a frame
  } tgStrobe_t;

endpackage

// File: rtl/frame_tgen_ctrl.sv
module frame_tgen_ctrl
  import frame_tgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shadowEn,
  input  logic      lastPix,
  output tgStrobe_t strb
);

  logic running;

  // While idle, every cycle counts as a boundary so an enable starts promptly.
  always_comb begin
    strb.load = !running || lastPix;
    strb.run  = running;
  end

  always_ff @(posedge clk) begin
    if (rst)            running <= 1'b0;
    else if (strb.load) running <= shadowEn;
  end

  // R9: a running frame is never cut short before its last pixel
  a_r9_run_until_boundary: assert property (@(posedge clk) disable iff (rst)
    (running && !lastPix) |=> running);

endmodule

// File: rtl/frame_tgen_dp.sv
module frame_tgen_dp
  import frame_tgen_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int H_W   = 16,
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  tgStrobe_t        strb,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  output logic             shadowEn,
  output logic             lastPix,
  output logic             pixReady,
  output logic [PIX_W-1:0] pixOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic             frameStrobe
);

  typedef struct packed {
    logic             en;
    logic             hLow;
    logic             vLow;
    logic [H_W-1:0]   hPeriod;
    logic [H_W-1:0]   hPulse;
    logic [H_W-1:0]   hStart;
    logic [H_W-1:0]   hEnd;
    logic [CNT_W-1:0] frameLen;
    logic [CNT_W-1:0] vsLen;
    logic [CNT_W-1:0] vStart;
    logic [CNT_W-1:0] vEnd;
    logic [CNT_W-1:0] skew;
    logic [PIX_W-1:0] fill;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{fill: {PIX_W{1'b1}}, default: '0};

  cfg_t shadowQ, actQ;
  logic [CNT_W-1:0] pos;
  logic [H_W-1:0]   hCnt;
  logic             uflowQ;
  logic             hWrap, deNow, hsAct, vsAct;
  logic [CNT_W-1:0] vLo, vHi;

  // Shadow register file
  always_ff @(posedge clk) begin
    if (rst) shadowQ <= CFG_RESET;
    else if (wrEn) begin
      case (wrAddr)
        REG_CTRL:   {shadowQ.vLow, shadowQ.hLow, shadowQ.en} <= wrData[2:0];
        REG_LINE:   {shadowQ.hPulse, shadowQ.hPeriod} <= wrData[2*H_W-1:0];
        REG_HWIN:   {shadowQ.hEnd, shadowQ.hStart} <= wrData[2*H_W-1:0];
        REG_FRAME:  shadowQ.frameLen <= wrData;
        REG_VSLEN:  shadowQ.vsLen <= wrData;
        REG_VSTART: shadowQ.vStart <= wrData;
        REG_VEND:   shadowQ.vEnd <= wrData;
        REG_SKEW:   shadowQ.skew <= wrData;
        REG_FILL:   shadowQ.fill <= wrData[PIX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            actQ <= CFG_RESET;
    else if (strb.load) actQ <= shadowQ;
  end

  assign shadowEn = shadowQ.en;

  // Frame-linear and in-line counters
  assign lastPix = ({1'b0, pos} + 1'b1) >= {1'b0, actQ.frameLen};
  assign hWrap   = ({1'b0, hCnt} + 1'b1) >= {1'b0, actQ.hPeriod};

  always_ff @(posedge clk) begin
    if (rst || strb.load) begin
      pos  <= '0;
      hCnt <= '0;
    end else if (strb.run) begin
      pos  <= pos + 1'b1;
      hCnt <= hWrap ? '0 : hCnt + 1'b1;
    end
  end

  // Window decode
  assign vLo   = actQ.vStart + actQ.skew;
  assign vHi   = actQ.vEnd + actQ.skew;
  assign deNow = strb.run && (hCnt >= actQ.hStart) && (hCnt <= actQ.hEnd)
                 && (pos >= vLo) && (pos <= vHi);
  assign hsAct = strb.run && (hCnt < actQ.hPulse);
  assign vsAct = strb.run && (pos < actQ.vsLen);
  assign pixReady = deNow;

  // Underflow latch: sticky until the next frame boundary
  always_ff @(posedge clk) begin
    if (rst || strb.load)       uflowQ <= 1'b0;
    else if (deNow && !pixValid) uflowQ <= 1'b1;
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pixOut      <= '0;
      hsyncOut    <= 1'b0;
      vsyncOut    <= 1'b0;
      deOut       <= 1'b0;
      frameStrobe <= 1'b0;
    end else begin
      pixOut      <= !deNow ? '0 : ((uflowQ || !pixValid) ? actQ.fill : pixIn);
      hsyncOut    <= hsAct ^ actQ.hLow;
      vsyncOut    <= vsAct ^ actQ.vLow;
      deOut       <= deNow;
      frameStrobe <= strb.run && (pos == '0);
    end
  end

  // R2: linear count stays inside the frame
  a_r2_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
    (strb.run && actQ.frameLen != '0) |-> (pos < actQ.frameLen));

  // R3: in-line count stays inside the line
  a_r3_col_in_line: assert property (@(posedge clk) disable iff (rst)
    (strb.run && actQ.hPeriod != '0) |-> (hCnt < actQ.hPeriod));

  // R1: working set only changes at a boundary
  a_r1_active_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(actQ));

  // R9: idle generator emits no video and no strobe
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> (!deOut && !frameStrobe));

  // R8: underflow persists for the rest of the frame
  a_r8_fill_sticky: assert property (@(posedge clk) disable iff (rst)
    (uflowQ && !strb.load) |=> uflowQ);

endmodule

// File: rtl/frame_tgen.sv
module frame_tgen
  import frame_tgen_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int H_W   = 16,
  parameter int PIX_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic              pixValid,
  output logic              pixReady,
  output logic [PIX_W-1:0]  pixOut,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              frameStrobe
);

  tgStrobe_t strb;
  logic      shadowEn;
  logic      lastPix;

  frame_tgen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shadowEn (shadowEn),
    .lastPix  (lastPix),
    .strb     (strb)
  );

  frame_tgen_dp #(.CNT_W(CNT_W), .H_W(H_W), .PIX_W(PIX_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strb        (strb),
    .pixIn       (pixIn),
    .pixValid    (pixValid),
    .shadowEn    (shadowEn),
    .lastPix     (lastPix),
    .pixReady    (pixReady),
    .pixOut      (pixOut),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .deOut       (deOut),
    .frameStrobe (frameStrobe)
  );

endmodule

// File: tb/frame_tgen_tb.sv
module frame_tgen_tb;

  localparam int HTOT = 10, HDISP = 5, HSS = 7, HSE = 9;
  localparam int VTOT = 7,  VDISP = 4, VSS = 5, VSE = 6;
  localparam int P      = VTOT * HTOT;
  localparam int VSLEN  = (VSE - VSS) * HTOT;
  localparam int HSTART = HTOT - HSS;
  localparam int HEND   = HTOT - (HSS - HDISP) - 1;
  localparam int VSTART = (VTOT - VSS) * HTOT;
  localparam int VEND   = P - (VSS - VDISP) * HTOT - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [23:0] pixIn = '0;
  logic pixValid = 1'b1;
  logic pixReady, hsyncOut, vsyncOut, deOut, frameStrobe;
  logic [23:0] pixOut;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  frame_tgen u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixIn(pixIn), .pixValid(pixValid), .pixReady(pixReady), .pixOut(pixOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .frameStrobe(frameStrobe)
  );

  function automatic logic [23:0] pat(input int k);
    return 24'hC30000 | 24'(k);
  endfunction

  function automatic logic expDe(input int k, input int skew);
    int col = k % HTOT;
    return (k < P) && col >= HSTART && col <= HEND && k >= VSTART + skew && k <= VEND + skew;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Sweep one frame pixel by pixel; optional write at wrK and underflow at uflK.
  task automatic runFrame(input int pulse, input int skew, input logic hLow, input logic vLow,
                          input int uflK, input logic [23:0] fillC,
                          input int wrK, input logic [3:0] wa, input logic [31:0] wd);
    int n = 0;
    logic [23:0] ep;
    @(negedge clk);
    while (!frameStrobe && n < 500) begin @(negedge clk); n++; end
    chk("R2", "frame start found", 32'(frameStrobe), 32'd1);
    for (int k = 0; k < P; k++) begin
      if (wrEn) wrEn = 1'b0;
      chk("R2", "strobe", 32'(frameStrobe), 32'(k == 0));
      chk("R3", "hsync", 32'(hsyncOut), 32'(((k % HTOT) < pulse) ^ hLow));
      chk("R4", "vsync", 32'(vsyncOut), 32'((k < VSLEN) ^ vLow));
      chk("R7", "de", 32'(deOut), 32'(expDe(k, skew)));
      ep = !expDe(k, skew) ? 24'h0 : ((uflK >= 0 && k >= uflK) ? fillC : pat(k));
      chk("R8", "pixel", 32'(pixOut), 32'(ep));
      chk("R10", "ready", 32'(pixReady), 32'(expDe(k + 1, skew)));
      pixIn    = pat(k + 1);
      pixValid = !(k + 1 == uflK);
      if (k == wrK) begin wrEn = 1'b1; wrAddr = wa; wrData = wd; end
      if (k < P - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11", "hsync", 32'(hsyncOut), 0);
    chk("R11", "vsync", 32'(vsyncOut), 0);
    chk("R11", "de", 32'(deOut), 0);
    chk("R11", "strobe", 32'(frameStrobe), 0);
    chk("R11", "pixel", 32'(pixOut), 0);
    chk("R11", "ready", 32'(pixReady), 0);

    wrReg(4'd1, {16'd2, 16'(HTOT)});
    wrReg(4'd2, {16'(HEND), 16'(HSTART)});
    wrReg(4'd3, 32'(P));
    wrReg(4'd4, 32'(VSLEN));
    wrReg(4'd5, 32'(VSTART));
    wrReg(4'd6, 32'(VEND));
    wrReg(4'd7, 32'd0);
    pixIn = pat(0); pixValid = 1'b1;
    wrReg(4'd0, 32'd1);

    // R1/R6: frame A, skew write mid-frame must not apply yet
    runFrame(2, 0, 0, 0, -1, 24'hFFFFFF, 30, 4'd7, 32'd3);
    // R7/R8: frame B, skew 3, underflow with reset fill; R1 pulse write on boundary cycle
    runFrame(2, 3, 0, 0, 35, 24'hFFFFFF, P - 2, 4'd1, {16'd3, 16'(HTOT)});
    // R1: frame C keeps old pulse; R8 recovered; R5 polarity write
    runFrame(2, 3, 0, 0, -1, 24'hFFFFFF, 10, 4'd0, 32'd7);
    // R5: frame D with active-low syncs and new pulse; new fill colour written
    runFrame(3, 3, 1, 1, -1, 24'hFFFFFF, 5, 4'd8, 32'h0000FF00);
    // R9: frame E completes despite mid-frame disable; R8 new fill
    runFrame(3, 3, 1, 1, 45, 24'h00FF00, 50, 4'd0, 32'd6);

    // R9: idle afterwards, syncs at inactive (high) level
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk("R9", "idle strobe", 32'(frameStrobe), 0);
      chk("R9", "idle de", 32'(deOut), 0);
      chk("R9", "idle hsync", 32'(hsyncOut), 1);
      chk("R9", "idle vsync", 32'(vsyncOut), 1);
      chk("R9", "idle ready", 32'(pixReady), 0);
    end

    // R9: re-enable, active-high syncs
    wrReg(4'd0, 32'd1);
    runFrame(3, 3, 0, 0, -1, 24'h00FF00, -1, 4'd0, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule